// File: doc/BRIEF.md
# APB GPIO Controller with Port-A Interrupts

A memory-mapped general-purpose I/O block that sits behind an APB slave port. It serves up to four ports of up to 32 lines each. Every port has a data register whose bits drive the pad outputs and a direction register whose bits drive the pad output enables. Each port also has a read-only view of its pad inputs, taken after a two-flop synchronizer. Software uses these registers to drive lines, to turn them around, and to sample them.

The first port (port A) adds per-line interrupt logic. Each line has an enable, a mask, a level-or-edge type and a polarity. Detected edges are latched until software clears them by writing a 1 to the end-of-interrupt register. Each line can also be given an input filter: it accepts a new value only after that value has been stable for a set number of cycles. All unmasked pending lines are ORed onto a single interrupt output.

Top module: `apb_gpio_ctrl`

## Requirements
- R1: After reset every register reads 0, and pad_out, pad_oe and irq are 0.
- R2: The data register of port n sits at byte offset n*0x0C. It drives pad_out[n*NLINES +: NLINES] one cycle after the write and reads back the written value.
- R3: The direction register of port n sits at offset 0x04 + n*0x0C. A bit of 1 sets the matching pad_oe bit, so that line is driven as an output. The register reads back the written value.
- R4: Offset 0x50 + n*0x04 reads port n's pad inputs after two clock edges of synchronization. The debounce filter does not change this value.
- R5: Port A interrupt registers: enable at 0x30 (1 = enabled), mask at 0x34 (1 = masked), type at 0x38 (1 = edge, 0 = level), polarity at 0x3C (1 = active-high or rising, 0 = active-low or falling), masked status at 0x40 (read-only), raw status at 0x44 (read-only), debounce enable at 0x48, and end-of-interrupt at 0x4C (write-only, reads 0). Bit i belongs to line i.
- R6: On an enabled level-type line, the raw status bit is 1 exactly while the filtered input equals the polarity bit. It is not latched.
- R7: On an enabled edge-type line, the selected edge sets a latched raw bit, whether or not the line is masked. The bit stays set until the end-of-interrupt register is written with a 1 in that bit. Zero bits in that write, and writes to level-type lines, have no effect. An edge of the opposite direction does not set the bit.
- R8: Status equals raw & ~mask, and irq is the OR of all status bits.
- R9: Clearing a line's enable bit removes its raw status and discards its latched edge. Enabling the line again does not restore the edge.
- R10: When a line's debounce bit is set, its filtered value follows a new synchronized input only after DB_CYCLES consecutive cycles at that value. A shorter pulse has no effect. Lines without the debounce bit react to a one-cycle pulse.
- R11: Inputs of ports other than port A never affect status or irq.
- R12: Writes to unmapped offsets (for example 0x2C, 0x60) change nothing, and reads from them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | AW | APB byte address |
| pwdata | input | DW | APB write data |
| prdata | output | DW | APB read data, valid in the access phase |
| pad_in | input | NPORTS*NLINES | Pad input values, asynchronous |
| pad_out | output | NPORTS*NLINES | Pad output values |
| pad_oe | output | NPORTS*NLINES | Pad output enables (1 = drive) |
| irq | output | 1 | Combined interrupt |

## Verification
The bench targets the edge latch:
- It applies a pulse whose edge is opposite to the programmed one; a detector that fires on both edges would report it.
- It writes an end-of-interrupt of zero or of another line's bit; a clear that is not bit-wise would drop the pending edge.
- It raises an edge while the line is masked; a design that blocked latching under the mask would lose that edge after the unmask.

It runs the debounce filter with pulses one cycle shorter than the limit and with long holds. An off-by-one counter either passes the short pulse or delays the accepted edge, and the bench sees either as a status or irq mismatch in that cycle.

It disables and re-enables a latched line to catch stale pending bits. It toggles every line of the other ports to show they cannot reach irq. It writes unmapped offsets to catch loose address decoding.

// File: rtl/apb_gpio_ctrl.sv
module apb_gpio_ctrl #(
  parameter int NPORTS    = 4,
  parameter int NLINES    = 32,
  parameter int DB_CYCLES = 4,
  parameter int AW        = 8,
  parameter int DW        = 32
) (
  input  logic                     pclk,
  input  logic                     presetn,
  input  logic                     psel,
  input  logic                     penable,
  input  logic                     pwrite,
  input  logic [AW-1:0]            paddr,
  input  logic [DW-1:0]            pwdata,
  output logic [DW-1:0]            prdata,
  input  logic [NPORTS*NLINES-1:0] pad_in,
  output logic [NPORTS*NLINES-1:0] pad_out,
  output logic [NPORTS*NLINES-1:0] pad_oe,
  output logic                     irq
);
  localparam int PW       = NPORTS * NLINES;
  localparam int CW       = $clog2(DB_CYCLES + 1);
  localparam int STRIDE   = 12;
  localparam int EXT_BASE = 'h50;
  localparam logic [AW-1:0] A_EN   = AW'('h30);
  localparam logic [AW-1:0] A_MASK = AW'('h34);
  localparam logic [AW-1:0] A_TYPE = AW'('h38);
  localparam logic [AW-1:0] A_POL  = AW'('h3C);
  localparam logic [AW-1:0] A_STAT = AW'('h40);
  localparam logic [AW-1:0] A_RAW  = AW'('h44);
  localparam logic [AW-1:0] A_DEB  = AW'('h48);
  localparam logic [AW-1:0] A_EOI  = AW'('h4C);

  logic [NLINES-1:0] dr  [NPORTS];
  logic [NLINES-1:0] ddr [NPORTS];
  logic [PW-1:0]     s1, s2;
  logic [NLINES-1:0] en, mask, etype, pol, deb, db, prev, lat;
  logic [CW-1:0]     cnt [NLINES];
  logic [NLINES-1:0] filt, hit, clr, raw, status, rdata;

  wire               wr = psel & penable & pwrite;
  wire  [NLINES-1:0] wv = pwdata[NLINES-1:0];

  assign filt   = (deb & db) | (~deb & s2[NLINES-1:0]);
  assign hit    = en & etype & ((pol & filt & ~prev) | (~pol & ~filt & prev));
  assign clr    = (wr && paddr == A_EOI) ? wv : '0;
  assign raw    = en & ((~etype & ~(filt ^ pol)) | (etype & lat));
  assign status = raw & ~mask;
  assign irq    = |status;
  assign prdata = DW'(rdata);

  always_comb begin
    for (int p = 0; p < NPORTS; p++) begin
      pad_out[p*NLINES +: NLINES] = dr[p];
      pad_oe[p*NLINES +: NLINES]  = ddr[p];
    end
  end

  always_comb begin
    rdata = '0;
    for (int p = 0; p < NPORTS; p++) begin
      if (paddr == AW'(p*STRIDE))     rdata = dr[p];
      if (paddr == AW'(p*STRIDE + 4)) rdata = ddr[p];
      if (paddr == AW'(EXT_BASE + p*4)) rdata = s2[p*NLINES +: NLINES];
    end
    case (paddr)
      A_EN:    rdata = en;
      A_MASK:  rdata = mask;
      A_TYPE:  rdata = etype;
      A_POL:   rdata = pol;
      A_STAT:  rdata = status;
      A_RAW:   rdata = raw;
      A_DEB:   rdata = deb;
      default: ;
    endcase
  end

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      s1 <= '0; s2 <= '0;
      en <= '0; mask <= '0; etype <= '0; pol <= '0; deb <= '0;
      db <= '0; prev <= '0; lat <= '0;
      for (int p = 0; p < NPORTS; p++) begin
        dr[p]  <= '0;
        ddr[p] <= '0;
      end
      for (int i = 0; i < NLINES; i++) cnt[i] <= '0;
    end else begin
      s1   <= pad_in;
      s2   <= s1;
      prev <= filt;
      lat  <= en & ((lat & ~clr) | hit);
      for (int i = 0; i < NLINES; i++) begin
        if (s2[i] != db[i]) begin
          if (cnt[i] == CW'(DB_CYCLES - 1)) begin
            db[i]  <= s2[i];
            cnt[i] <= '0;
          end else begin
            cnt[i] <= cnt[i] + CW'(1);
          end
        end else begin
          cnt[i] <= '0;
        end
      end
      if (wr) begin
        for (int p = 0; p < NPORTS; p++) begin
          if (paddr == AW'(p*STRIDE))     dr[p]  <= wv;
          if (paddr == AW'(p*STRIDE + 4)) ddr[p] <= wv;
        end
        case (paddr)
          A_EN:    en    <= wv;
          A_MASK:  mask  <= wv;
          A_TYPE:  etype <= wv;
          A_POL:   pol   <= wv;
          A_DEB:   deb   <= wv;
          default: ;
        endcase
      end
    end
  end

  // R2: a port-A data write reaches the pads on the next cycle
  a_r2_data_to_pad: assert property (@(posedge pclk) disable iff (!presetn)
    (wr && paddr == '0) |=> pad_out[NLINES-1:0] == $past(wv));

  // R7: a latched edge survives unless an EOI write carries a 1 in its bit
  a_r7_edge_sticky: assert property (@(posedge pclk) disable iff (!presetn)
    (lat[0] && en[0] && !(wr && paddr == A_EOI && pwdata[0])) |=> lat[0]);

  // R8: irq needs some enabled, unmasked line
  a_r8_irq_needs_source: assert property (@(posedge pclk) disable iff (!presetn)
    irq |-> |(en & ~mask));

  // R8: fully masked port never interrupts
  a_r8_all_masked_quiet: assert property (@(posedge pclk) disable iff (!presetn)
    (&mask) |-> !irq);

  // R9: a disabled line holds no latched edge one cycle later
  a_r9_disable_drops: assert property (@(posedge pclk) disable iff (!presetn)
    !en[0] |=> !lat[0]);
endmodule

// File: tb/apb_gpio_ctrl_tb.sv
`timescale 1ns/1ps
module apb_gpio_ctrl_tb_top;
  localparam int NP = 4, NL = 32, DB = 4;
  localparam int PW = NP * NL;

  logic          clk = 0, rstn = 0;
  logic          psel = 0, penable = 0, pwrite = 0;
  logic [7:0]    paddr = '0;
  logic [31:0]   pwdata = '0;
  logic [31:0]   prdata;
  logic [PW-1:0] pad_in = '0;
  logic [PW-1:0] pad_out, pad_oe;
  logic          irq;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  apb_gpio_ctrl #(.NPORTS(NP), .NLINES(NL), .DB_CYCLES(DB)) dut_i (
    .pclk(clk), .presetn(rstn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq));

  // behavioural reference
  bit [31:0]  m_dr [NP];
  bit [31:0]  m_ddr[NP];
  bit [PW-1:0] m_s1, m_s2;
  bit [31:0]  m_en, m_mask, m_type, m_pol, m_deb, m_db, m_prev, m_lat;
  int         m_cnt[NL];

  function automatic bit [31:0] m_filt();
    return (m_deb & m_db) | (~m_deb & m_s2[31:0]);
  endfunction
  function automatic bit [31:0] m_raw();
    bit [31:0] f = m_filt();
    return m_en & ((~m_type & ~(f ^ m_pol)) | (m_type & m_lat));
  endfunction
  function automatic bit [31:0] m_read(input logic [7:0] a);
    for (int p = 0; p < NP; p++) begin
      if (a == 8'(p*12))      return m_dr[p];
      if (a == 8'(p*12 + 4))  return m_ddr[p];
      if (a == 8'('h50 + p*4)) return m_s2[p*NL +: NL];
    end
    case (a)
      8'h30: return m_en;
      8'h34: return m_mask;
      8'h38: return m_type;
      8'h3C: return m_pol;
      8'h40: return m_raw() & ~m_mask;
      8'h44: return m_raw();
      8'h48: return m_deb;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstn) begin
      m_s1 = 0; m_s2 = 0; m_en = 0; m_mask = 0; m_type = 0; m_pol = 0;
      m_deb = 0; m_db = 0; m_prev = 0; m_lat = 0;
      for (int p = 0; p < NP; p++) begin m_dr[p] = 0; m_ddr[p] = 0; end
      for (int i = 0; i < NL; i++) m_cnt[i] = 0;
    end else begin
      bit [31:0] f, rise, fall, trig, eoi;
      bit w;
      w    = psel && penable && pwrite;
      f    = m_filt();
      rise = f & ~m_prev;
      fall = ~f & m_prev;
      trig = m_en & m_type & ((m_pol & rise) | (~m_pol & fall));
      eoi  = (w && paddr == 8'h4C) ? pwdata : 0;
      m_lat  = m_en & ((m_lat & ~eoi) | trig);
      m_prev = f;
      for (int i = 0; i < NL; i++) begin
        if (m_s2[i] != m_db[i]) begin
          if (m_cnt[i] == DB - 1) begin m_db[i] = m_s2[i]; m_cnt[i] = 0; end
          else m_cnt[i]++;
        end else m_cnt[i] = 0;
      end
      m_s2 = m_s1;
      m_s1 = pad_in;
      if (w) begin
        for (int p = 0; p < NP; p++) begin
          if (paddr == 8'(p*12))     m_dr[p]  = pwdata;
          if (paddr == 8'(p*12 + 4)) m_ddr[p] = pwdata;
        end
        case (paddr)
          8'h30: m_en   = pwdata;
          8'h34: m_mask = pwdata;
          8'h38: m_type = pwdata;
          8'h3C: m_pol  = pwdata;
          8'h48: m_deb  = pwdata;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (!done) begin
      bit [PW-1:0] eo, ee;
      for (int p = 0; p < NP; p++) begin
        eo[p*NL +: NL] = m_dr[p];
        ee[p*NL +: NL] = m_ddr[p];
      end
      chk("R2 pad_out", pad_out, eo);
      chk("R3 pad_oe", pad_oe, ee);
      chk("R8 irq", PW'(irq), PW'(|(m_raw() & ~m_mask)));
      if (psel && penable && !pwrite)
        chk("R5 prdata", PW'(prdata), PW'(m_read(paddr)));
    end
  end

  task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1; psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(posedge clk); #1; penable = 1;
    @(posedge clk); #1; psel = 0; penable = 0; pwrite = 0;
  endtask
  task automatic apb_rd(input logic [7:0] a, output logic [31:0] d);
    @(posedge clk); #1; psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(posedge clk); #1; penable = 1;
    @(negedge clk); d = prdata;
    @(posedge clk); #1; psel = 0; penable = 0;
  endtask
  task automatic rdchk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    apb_rd(a, d);
    chk(tag, PW'(d), PW'(exp));
  endtask
  task automatic setpad(input logic [PW-1:0] v);
    @(posedge clk); #1; pad_in = v;
  endtask
  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask
  task automatic irqchk(input string tag, input logic exp);
    @(negedge clk); chk(tag, PW'(irq), PW'(exp));
  endtask

  task automatic finish_all();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog act=running exp=finished");
    finish_all();
  end

  initial begin
    repeat (3) @(posedge clk); #1; rstn = 1;
    // R1 reset state
    @(negedge clk);
    chk("R1 pad_out", pad_out, '0);
    chk("R1 pad_oe", pad_oe, '0);
    chk("R1 irq", PW'(irq), '0);
    rdchk("R1 en", 8'h30, 0);
    rdchk("R1 dr0", 8'h00, 0);
    // R2 / R3 per-port registers
    for (int p = 0; p < NP; p++) begin
      apb_wr(8'(p*12), 32'hA5A5_0000 + 32'(p));
      apb_wr(8'(p*12 + 4), 32'h0F0F_0000 + 32'(p));
    end
    rdchk("R2 dr3 readback", 8'h24, 32'hA5A5_0003);
    rdchk("R3 ddr2 readback", 8'h1C, 32'h0F0F_0002);
    chk("R2 pad_out port1", PW'(pad_out[63:32]), PW'(32'hA5A5_0001));
    chk("R3 pad_oe port3", PW'(pad_oe[127:96]), PW'(32'h0F0F_0003));
    // R4 external readback
    setpad({32'h4444_0004, 32'h3333_0003, 32'h2222_0002, 32'h0});
    idle(3);
    rdchk("R4 ext port1", 8'h54, 32'h2222_0002);
    rdchk("R4 ext port3", 8'h5C, 32'h4444_0004);
    setpad('0);
    idle(3);
    // R5 interrupt setup: line0 level high, line1 level low, line2 rising, line3 falling
    apb_wr(8'h3C, 32'h5);
    apb_wr(8'h38, 32'hC);
    apb_wr(8'h34, 32'h0);
    apb_wr(8'h30, 32'hF);
    rdchk("R5 type readback", 8'h38, 32'hC);
    rdchk("R5 eoi reads zero", 8'h4C, 0);
    idle(2);
    rdchk("R6 level low active", 8'h44, 32'h2);
    irqchk("R8 irq from level", 1);
    setpad(PW'(32'h2));
    idle(4);
    rdchk("R6 level follows input", 8'h44, 0);
    irqchk("R6 irq drops", 0);
    // R7 edge latch
    setpad(PW'(32'h6)); idle(4);
    rdchk("R7 rising latched", 8'h44, 32'h4);
    setpad(PW'(32'h2)); idle(4);
    rdchk("R7 sticky after fall", 8'h44, 32'h4);
    apb_wr(8'h4C, 32'h0);
    rdchk("R7 eoi zero no effect", 8'h44, 32'h4);
    apb_wr(8'h4C, 32'h2);
    rdchk("R7 eoi other bit", 8'h44, 32'h4);
    apb_wr(8'h4C, 32'h4);
    rdchk("R7 eoi clears", 8'h44, 0);
    setpad(PW'(32'hA)); idle(4);
    rdchk("R7 opposite edge ignored", 8'h44, 0);
    setpad(PW'(32'h2)); idle(4);
    rdchk("R7 falling latched", 8'h44, 32'h8);
    // R8 masking
    apb_wr(8'h34, 32'h8);
    rdchk("R8 masked status", 8'h40, 0);
    irqchk("R8 masked irq", 0);
    apb_wr(8'h34, 32'h0);
    rdchk("R8 unmasked status", 8'h40, 32'h8);
    apb_wr(8'h4C, 32'hFFFF_FFFF);
    rdchk("R7 clear all", 8'h44, 0);
    apb_wr(8'h34, 32'h4);
    setpad(PW'(32'h6)); idle(1); setpad(PW'(32'h2)); idle(4);
    rdchk("R7 latched while masked", 8'h40, 0);
    apb_wr(8'h34, 32'h0);
    rdchk("R7 shows after unmask", 8'h40, 32'h4);
    apb_wr(8'h4C, 32'h4);
    // R9 disable drops pending
    setpad(PW'(32'h6)); idle(4);
    apb_wr(8'h30, 32'hB);
    rdchk("R9 disabled raw", 8'h44, 0);
    apb_wr(8'h30, 32'hF);
    idle(2);
    rdchk("R9 re-enable no stale", 8'h44, 0);
    setpad(PW'(32'h2)); idle(4);
    // R10 debounce on line4 (rising edge)
    apb_wr(8'h38, 32'h1C);
    apb_wr(8'h3C, 32'h15);
    apb_wr(8'h48, 32'h10);
    apb_wr(8'h30, 32'h1F);
    setpad(PW'(32'h12)); idle(2); setpad(PW'(32'h2));
    idle(10);
    rdchk("R10 short pulse filtered", 8'h44, 0);
    setpad(PW'(32'h6)); setpad(PW'(32'h2)); idle(4);
    rdchk("R10 unfiltered line pulse", 8'h44, 32'h4);
    apb_wr(8'h4C, 32'h4);
    setpad(PW'(32'h12)); idle(2);
    rdchk("R4 ext not debounced", 8'h50, 32'h12);
    idle(8);
    rdchk("R10 held input accepted", 8'h44, 32'h10);
    apb_wr(8'h4C, 32'h10);
    rdchk("R10 cleared", 8'h44, 0);
    setpad(PW'(32'h2)); idle(8);
    // R11 other ports do not interrupt
    apb_wr(8'h30, 32'hFFFF_FFFF);
    apb_wr(8'h38, 32'hFFFF_FFFC);
    apb_wr(8'h3C, 32'hFFFF_FFFD);
    setpad({96'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 32'h2}); idle(4);
    setpad(PW'(32'h2)); idle(4);
    rdchk("R11 status unaffected", 8'h40, 0);
    irqchk("R11 irq quiet", 0);
    // R12 unmapped offsets
    apb_wr(8'h2C, 32'hFFFF_FFFF);
    apb_wr(8'h60, 32'hFFFF_FFFF);
    rdchk("R12 read 0x2C", 8'h2C, 0);
    rdchk("R12 read 0x60", 8'h60, 0);
    @(negedge clk);
    chk("R12 pads unchanged", PW'(pad_out[31:0]), PW'(32'hA5A5_0000));
    idle(2);
    finish_all();
  end
endmodule